// File: doc/BRIEF.md
# Two-Entry Byte Buffers with Service and Event Interrupts

This block sits between a two-wire bus controller's shift engine and a 16-bit register bus. It holds two small byte queues, each two entries deep. The transmit queue is filled from the register bus and drained by the engine. The receive queue is filled by the engine and drained from the register bus. Each queue reports its fill as a 2-bit code and raises a service event. That event fires either when one entry is available or only when both entries are, selected per queue.

Each queue is a three-state machine with the states EMPTY, ONE and FULL. The state codes are also the fill codes. The transitions are:
- single push: EMPTY→ONE and ONE→FULL.
- single pop: FULL→ONE and ONE→EMPTY.
- pair push: EMPTY→FULL.
- pair pop: FULL→EMPTY.
- push and pop in the same cycle: the state is kept, or EMPTY→ONE when the pop finds nothing.
- flush: any state→EMPTY.

Engine-side events and the two service events are latched into one write-one-to-clear status register. A mask register selects which of its bits drive the single interrupt line. Overflow and underflow of the queues from the bus side are latched in a separate write-one-to-clear error register.

Registers are 16 bits wide at 32-bit-aligned byte offsets on `bus_addr`. The offsets are:

| Offset | Register |
|---|---|
| 0x18 | Buffer error |
| 0x20 | Interrupt status |
| 0x24 | Interrupt mask |
| 0x28 | Queue control |
| 0x2C | Queue fill |
| 0x80 | Transmit byte |
| 0x84 | Transmit pair |
| 0x88 | Receive byte |
| 0x8C | Receive pair |

Any other offset reads as zero and ignores writes. A bus read is a cycle with `bus_sel` high and `bus_wr` low. `bus_rdata` is combinational in that cycle, and the pop caused by the read takes effect at the closing clock edge.

Top module: `tw_buf_irq`

## Requirements
- R1: After reset both queues are EMPTY, and the fill, interrupt status, mask and error registers read 0. `irq` is low.
- R2: Fill register bits 1:0 give the transmit queue fill and bits 3:2 the receive queue fill. The codes are 00 for empty, 01 for one byte and 11 for two bytes. Code 10 never occurs.
- R3: Bytes leave each queue in arrival order. `tx_byte` shows the oldest transmit byte while `tx_avail` is high. A receive byte read (0x88) returns the oldest byte in bits 7:0, with bits 15:8 zero.
- R4: A pair write (0x84) queues bits 7:0 first, then bits 15:8, and needs two free entries. A pair read (0x8C) needs two stored bytes and returns the older byte in bits 7:0 and the newer in bits 15:8.
- R5: While queue-control bit 0 (transmit) or bit 1 (receive) is 1, that queue is held EMPTY and bytes pushed into it are dropped without an error.
- R6: A transmit write that does not fit sets error bit 5 (0x18) and leaves the queue unchanged. A receive push into a full queue is dropped, and `rx_space` is low whenever the receive queue is FULL.
- R7: A receive byte read from an empty queue, or a pair read with fewer than two bytes, returns 0, sets error bit 4 and pops nothing.
- R8: Status bit 6 sets when the transmit service condition becomes true. With control bit 2 clear the condition is fill below two. With control bit 2 set it is an empty queue.
- R9: Status bit 7 sets when the receive service condition becomes true. With control bit 3 clear the condition is fill above zero. With control bit 3 set it is a full queue.
- R10: Event pulses set status bits: slave start bit 0, slave done bit 1, slave error bit 2, slave overflow bit 3, master done bit 4, master error bit 5.
- R11: Writing 1 to a status or error bit clears it and writing 0 leaves it. A bit that is set in the same cycle stays set.
- R12: `irq` is high exactly when some status bit and its mask bit (0x24, same position) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during the access cycle |
| tx_pop | input | 1 | Engine takes the oldest transmit byte |
| tx_avail | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_space | output | 1 | Receive queue has a free entry |
| ev_slv_start | input | 1 | Slave transfer started pulse |
| ev_slv_done | input | 1 | Slave transfer done pulse |
| ev_slv_err | input | 1 | Slave error pulse |
| ev_slv_ovf | input | 1 | Slave overflow pulse |
| ev_mst_done | input | 1 | Master transfer done pulse |
| ev_mst_err | input | 1 | Master error pulse |
| irq | output | 1 | Masked interrupt request |

## Verification
On every cycle the assertions hold the following:
- The fill codes stay legal.
- An empty receive read returns zero.
- A transmit write into a full queue raises the write error.
- A held flush keeps the queue empty.
- A master-done pulse is latched.
- An all-zero mask keeps `irq` low.

Only the bench scenarios show byte ordering through mixed single and pair accesses. They also show the edge behaviour of the service bits under both length settings, and that a same-cycle event beats a clearing write. The queue contents are compared against a bench model across a seeded random mix of bus and engine operations.

// File: rtl/tw_buf_pkg.sv
package tw_buf_pkg;
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'b00,
        LVL_ONE   = 2'b01,
        LVL_FULL  = 2'b11
    } lvl_e;

    localparam logic [7:0] OFF_ERR   = 8'h18;
    localparam logic [7:0] OFF_ISTAT = 8'h20;
    localparam logic [7:0] OFF_IMASK = 8'h24;
    localparam logic [7:0] OFF_FCTL  = 8'h28;
    localparam logic [7:0] OFF_FSTAT = 8'h2C;
    localparam logic [7:0] OFF_TX1   = 8'h80;
    localparam logic [7:0] OFF_TX2   = 8'h84;
    localparam logic [7:0] OFF_RX1   = 8'h88;
    localparam logic [7:0] OFF_RX2   = 8'h8C;

    localparam int CTL_TXFLUSH = 0;
    localparam int CTL_RXFLUSH = 1;
    localparam int CTL_TXLEN   = 2;
    localparam int CTL_RXLEN   = 3;
    localparam int ERR_RD_BIT  = 4;
    localparam int ERR_WR_BIT  = 5;
    localparam int NUM_EV      = 6;
endpackage

// File: rtl/tw_pair_fifo.sv
module tw_pair_fifo
    import tw_buf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           push_one,
    input  logic           push_two,
    input  logic [2*W-1:0] din,
    input  logic           pop_one,
    input  logic           pop_two,
    output lvl_e           lvl,
    output logic [W-1:0]   head,
    output logic [2*W-1:0] pair,
    output logic           push_ok,
    output logic           pop_ok
);
    lvl_e         lvl_n;
    logic [W-1:0] s0_q, s1_q, s0_n, s1_n;
    logic [2:0]   cnt, npop, rem, npush, cnt_n;

    always_comb begin
        unique case (lvl)
            LVL_EMPTY: cnt = 3'd0;
            LVL_ONE:   cnt = 3'd1;
            default:   cnt = 3'd2;
        endcase
        pop_ok  = pop_two ? (lvl == LVL_FULL) : (pop_one && lvl != LVL_EMPTY);
        npop    = !pop_ok ? 3'd0 : (pop_two ? 3'd2 : 3'd1);
        rem     = cnt - npop;
        npush   = push_two ? 3'd2 : (push_one ? 3'd1 : 3'd0);
        push_ok = !flush && (npush != 3'd0) && ((rem + npush) <= 3'd2);
        s0_n    = s0_q;
        s1_n    = s1_q;
        if (npop == 3'd1) s0_n = s1_q;
        if (push_ok) begin
            if (rem == 3'd0) begin
                s0_n = din[W-1:0];
                if (push_two) s1_n = din[2*W-1:W];
            end else begin
                s1_n = din[W-1:0];
            end
        end
        cnt_n = flush ? 3'd0 : rem + (push_ok ? npush : 3'd0);
        unique case (cnt_n)
            3'd0:    lvl_n = LVL_EMPTY;
            3'd1:    lvl_n = LVL_ONE;
            default: lvl_n = LVL_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl  <= LVL_EMPTY;
            s0_q <= '0;
            s1_q <= '0;
        end else begin
            lvl  <= lvl_n;
            s0_q <= s0_n;
            s1_q <= s1_n;
        end
    end

    assign head = s0_q;
    assign pair = {s1_q, s0_q};
endmodule

// File: rtl/tw_svc_irq.sv
module tw_svc_irq
    import tw_buf_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lvl_e          tx_lvl,
    input  lvl_e          rx_lvl,
    input  logic          tx_len,
    input  logic          rx_len,
    input  logic [NUM_EV-1:0] ev,
    input  logic          st_we,
    input  logic          mk_we,
    input  logic [SW-1:0] wdata,
    output logic [SW-1:0] stat,
    output logic [SW-1:0] mask,
    output logic          irq
);
    logic          tx_cond, rx_cond;
    logic [1:0]    cond_q;
    logic [SW-1:0] set_v, clr_v;

    always_comb begin
        tx_cond = tx_len ? (tx_lvl == LVL_EMPTY) : (tx_lvl != LVL_FULL);
        rx_cond = rx_len ? (rx_lvl == LVL_FULL)  : (rx_lvl != LVL_EMPTY);
        set_v   = '0;
        set_v[NUM_EV-1:0] = ev;
        set_v[NUM_EV]     = tx_cond & ~cond_q[0];
        set_v[NUM_EV+1]   = rx_cond & ~cond_q[1];
        clr_v   = st_we ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 2'b11;
            stat   <= '0;
            mask   <= '0;
        end else begin
            cond_q <= {rx_cond, tx_cond};
            stat   <= (stat & ~clr_v) | set_v;
            if (mk_we) mask <= wdata;
        end
    end

    assign irq = |(stat & mask);
endmodule

// File: rtl/tw_buf_irq.sv
module tw_buf_irq
    import tw_buf_pkg::*;
#(
    parameter int AW = 8,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [2*BW-1:0] bus_wdata,
    output logic [2*BW-1:0] bus_rdata,
    input  logic          tx_pop,
    output logic          tx_avail,
    output logic [BW-1:0] tx_byte,
    input  logic          rx_push,
    input  logic [BW-1:0] rx_byte,
    output logic          rx_space,
    input  logic          ev_slv_start,
    input  logic          ev_slv_done,
    input  logic          ev_slv_err,
    input  logic          ev_slv_ovf,
    input  logic          ev_mst_done,
    input  logic          ev_mst_err,
    output logic          irq
);
    localparam int DW = 2 * BW;
    localparam int SW = 8;

    logic            wr, rd;
    logic            tx_p1, tx_p2, rx_r1, rx_r2;
    logic            tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [3:0]      fctl;
    logic [1:0]      err_q;
    logic            wr_err, rd_err;
    lvl_e            tx_lvl, rx_lvl;
    logic [BW-1:0]   rx_head;
    logic [DW-1:0]   tx_pair, rx_pair;
    logic [SW-1:0]   stat, mask;

    assign wr    = bus_sel & bus_wr;
    assign rd    = bus_sel & ~bus_wr;
    assign tx_p1 = wr && bus_addr == AW'(OFF_TX1);
    assign tx_p2 = wr && bus_addr == AW'(OFF_TX2);
    assign rx_r1 = rd && bus_addr == AW'(OFF_RX1);
    assign rx_r2 = rd && bus_addr == AW'(OFF_RX2);

    tw_pair_fifo #(.W(BW)) tx_q (
        .clk(clk), .rst_n(rst_n), .flush(fctl[CTL_TXFLUSH]),
        .push_one(tx_p1), .push_two(tx_p2), .din(bus_wdata),
        .pop_one(tx_pop), .pop_two(1'b0),
        .lvl(tx_lvl), .head(tx_byte), .pair(tx_pair),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    tw_pair_fifo #(.W(BW)) rx_q (
        .clk(clk), .rst_n(rst_n), .flush(fctl[CTL_RXFLUSH]),
        .push_one(rx_push), .push_two(1'b0), .din({{BW{1'b0}}, rx_byte}),
        .pop_one(rx_r1), .pop_two(rx_r2),
        .lvl(rx_lvl), .head(rx_head), .pair(rx_pair),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    tw_svc_irq #(.SW(SW)) irq_u (
        .clk(clk), .rst_n(rst_n), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_len(fctl[CTL_TXLEN]), .rx_len(fctl[CTL_RXLEN]),
        .ev({ev_mst_err, ev_mst_done, ev_slv_ovf, ev_slv_err, ev_slv_done, ev_slv_start}),
        .st_we(wr && bus_addr == AW'(OFF_ISTAT)),
        .mk_we(wr && bus_addr == AW'(OFF_IMASK)),
        .wdata(bus_wdata[SW-1:0]),
        .stat(stat), .mask(mask), .irq(irq)
    );

    assign wr_err = (tx_p1 | tx_p2) & ~tx_push_ok & ~fctl[CTL_TXFLUSH];
    assign rd_err = (rx_r1 | rx_r2) & ~rx_pop_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fctl  <= '0;
            err_q <= '0;
        end else begin
            if (wr && bus_addr == AW'(OFF_FCTL)) fctl <= bus_wdata[3:0];
            err_q <= (err_q & ~((wr && bus_addr == AW'(OFF_ERR)) ?
                               {bus_wdata[ERR_WR_BIT], bus_wdata[ERR_RD_BIT]} : 2'b00))
                     | {wr_err, rd_err};
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                AW'(OFF_ERR):   begin
                    bus_rdata[ERR_WR_BIT] = err_q[1];
                    bus_rdata[ERR_RD_BIT] = err_q[0];
                end
                AW'(OFF_ISTAT): bus_rdata[SW-1:0] = stat;
                AW'(OFF_IMASK): bus_rdata[SW-1:0] = mask;
                AW'(OFF_FCTL):  bus_rdata[3:0] = fctl;
                AW'(OFF_FSTAT): bus_rdata[3:0] = {rx_lvl, tx_lvl};
                AW'(OFF_RX1):   bus_rdata[BW-1:0] = rx_pop_ok ? rx_head : '0;
                AW'(OFF_RX2):   bus_rdata = rx_pop_ok ? rx_pair : '0;
                default:        bus_rdata = '0;
            endcase
        end
    end

    assign tx_avail = tx_lvl != LVL_EMPTY;
    assign rx_space = rx_lvl != LVL_FULL;
endmodule

// File: rtl/tw_buf_irq_chk.sv
module tw_buf_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [15:0] bus_rdata,
    input logic        tx_pop,
    input logic        ev_mst_done,
    input logic        irq,
    input logic [1:0]  tx_lvl,
    input logic [1:0]  rx_lvl,
    input logic [3:0]  fctl,
    input logic [1:0]  err_q,
    input logic [7:0]  stat,
    input logic [7:0]  mask
);
    // R2
    lvl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lvl != 2'b10 && rx_lvl != 2'b10);

    // R7
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 8'h88 && rx_lvl == 2'b00) |-> bus_rdata == 16'h0);

    // R6
    tx_overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 8'h80 && tx_lvl == 2'b11 && !tx_pop && !fctl[0])
        |=> err_q[1]);

    // R5
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fctl[0] |=> tx_lvl == 2'b00);

    // R10
    mst_done_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mst_done |=> stat[4]);

    // R12
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'h00) |-> !irq);
endmodule

bind tw_buf_irq tw_buf_irq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tx_pop(tx_pop),
    .ev_mst_done(ev_mst_done), .irq(irq), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .fctl(fctl), .err_q(err_q), .stat(stat), .mask(mask)
);

// File: tb/tw_buf_irq_tb_top.sv
module tw_buf_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tx_pop = 1'b0, tx_avail;
    logic [7:0]  tx_byte;
    logic        rx_push = 1'b0, rx_space;
    logic [7:0]  rx_byte = '0;
    logic        ev_slv_start = 0, ev_slv_done = 0, ev_slv_err = 0;
    logic        ev_slv_ovf = 0, ev_mst_done = 0, ev_mst_err = 0;
    logic        irq;

    int checks = 0, fails = 0;
    logic [7:0] tq [2];
    logic [7:0] rq [2];
    int tn = 0, rn = 0;
    logic werr = 0, rerr = 0;

    always #2 clk = ~clk;

    tw_buf_irq dut_i (.*);

    function automatic logic [1:0] enc(int n);
        return (n == 0) ? 2'b00 : (n == 1) ? 2'b01 : 2'b11;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_reg(logic [7:0] a, output logic [15:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic eng_pop(output logic [7:0] b, output logic av);
        tx_pop = 1; #1 b = tx_byte; av = tx_avail;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic eng_push(logic [7:0] b, output logic sp);
        rx_push = 1; rx_byte = b; #1 sp = rx_space;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (1_000_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  b;
        logic        f;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1;
        idle(2);

        // R1 reset state
        rd_reg(8'h2C, d); chk("R1 fill", d, 16'h0);
        rd_reg(8'h20, d); chk("R1 status", d, 16'h0);
        rd_reg(8'h24, d); chk("R1 mask", d, 16'h0);
        rd_reg(8'h18, d); chk("R1 error", d, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);

        // R8 transmit service, per byte
        wr_reg(8'h80, 16'h00A1);
        rd_reg(8'h2C, d); chk("R2 tx one", d, 16'h0001);
        wr_reg(8'h80, 16'h00A2);
        rd_reg(8'h2C, d); chk("R2 tx full", d, 16'h0003);
        wr_reg(8'h80, 16'h00A3);
        rd_reg(8'h18, d); chk("R6 write error", d, 16'h0020);
        wr_reg(8'h18, 16'h0020);
        idle(1);
        rd_reg(8'h20, d); chk("R8 no svc while full", d & 16'h40, 16'h0);
        eng_pop(b, f); chk("R3 tx order 1", {8'd0, b}, 16'h00A1);
        idle(1);
        rd_reg(8'h20, d); chk("R8 svc per byte", d & 16'h40, 16'h40);
        wr_reg(8'h20, 16'h0040);
        rd_reg(8'h20, d); chk("R11 w1c svc", d & 16'h40, 16'h0);
        eng_pop(b, f); chk("R3 tx order 2", {8'd0, b}, 16'h00A2);

        // R8 transmit service, per pair
        wr_reg(8'h28, 16'h0004);
        wr_reg(8'h84, 16'hB2B1);
        rd_reg(8'h2C, d); chk("R4 pair fill", d, 16'h0003);
        eng_pop(b, f); chk("R4 pair low first", {8'd0, b}, 16'h00B1);
        idle(1);
        rd_reg(8'h20, d); chk("R8 no svc at one free", d & 16'h40, 16'h0);
        eng_pop(b, f); chk("R4 pair high second", {8'd0, b}, 16'h00B2);
        idle(1);
        rd_reg(8'h20, d); chk("R8 svc per pair", d & 16'h40, 16'h40);
        wr_reg(8'h20, 16'h00FF);

        // R9 receive service
        wr_reg(8'h28, 16'h0000);
        eng_push(8'hC1, f);
        idle(1);
        rd_reg(8'h20, d); chk("R9 svc per byte", d & 16'h80, 16'h80);
        wr_reg(8'h20, 16'h0080);
        wr_reg(8'h28, 16'h0008);
        rd_reg(8'h88, d); chk("R3 rx byte", d, 16'h00C1);
        eng_push(8'hC2, f);
        idle(1);
        rd_reg(8'h20, d); chk("R9 no svc at one", d & 16'h80, 16'h0);
        eng_push(8'hC3, f);
        idle(1);
        rd_reg(8'h20, d); chk("R9 svc per pair", d & 16'h80, 16'h80);
        eng_push(8'hC4, f); chk("R6 rx_space low when full", {15'd0, f}, 16'h0);
        rd_reg(8'h8C, d); chk("R4 pair read", d, 16'hC3C2);
        rd_reg(8'h8C, d); chk("R7 pair read empty", d, 16'h0);
        rd_reg(8'h18, d); chk("R7 read error", d, 16'h0010);
        wr_reg(8'h18, 16'h0030);
        rd_reg(8'h18, d); chk("R11 error w1c", d, 16'h0);
        wr_reg(8'h28, 16'h0000);
        wr_reg(8'h20, 16'h00FF);

        // R5 flush
        wr_reg(8'h80, 16'h0011);
        eng_push(8'h22, f);
        wr_reg(8'h28, 16'h0003);
        idle(1);
        rd_reg(8'h2C, d); chk("R5 flushed", d, 16'h0);
        wr_reg(8'h80, 16'h0033);
        eng_push(8'h44, f);
        rd_reg(8'h2C, d); chk("R5 push dropped", d, 16'h0);
        rd_reg(8'h18, d); chk("R5 no error", d, 16'h0);
        wr_reg(8'h28, 16'h0000);
        wr_reg(8'h80, 16'h0055);
        eng_pop(b, f); chk("R5 after flush", {8'd0, b}, 16'h0055);
        idle(2);
        wr_reg(8'h20, 16'h00FF);

        // R10, R11, R12 events and mask
        ev_slv_start = 1; ev_slv_done = 1; ev_slv_err = 1;
        ev_slv_ovf = 1; ev_mst_done = 1; ev_mst_err = 1;
        idle(1);
        ev_slv_start = 0; ev_slv_done = 0; ev_slv_err = 0;
        ev_slv_ovf = 0; ev_mst_done = 0; ev_mst_err = 0;
        rd_reg(8'h20, d); chk("R10 all events", d & 16'h3F, 16'h3F);
        chk("R12 masked off", {15'd0, irq}, 16'h0);
        wr_reg(8'h20, 16'h002F);
        rd_reg(8'h20, d); chk("R11 partial clear", d & 16'h3F, 16'h10);
        wr_reg(8'h24, 16'h0010);
        #1 chk("R12 irq on", {15'd0, irq}, 16'h1);
        wr_reg(8'h24, 16'h0020);
        #1 chk("R12 irq other bit", {15'd0, irq}, 16'h0);
        ev_slv_start = 1;
        wr_reg(8'h20, 16'h0001);
        ev_slv_start = 0;
        rd_reg(8'h20, d); chk("R11 set wins", d & 16'h01, 16'h01);
        wr_reg(8'h20, 16'h00FF);
        wr_reg(8'h24, 16'h0000);

        // R2 R3 R4 R6 R7 random mix against model
        for (int i = 0; i < 400; i++) begin
            logic [15:0] r;
            int op;
            op = $urandom % 6;
            r  = 16'($urandom);
            case (op)
                0: begin
                    wr_reg(8'h80, r);
                    if (tn < 2) begin tq[tn] = r[7:0]; tn++; end else werr = 1;
                end
                1: begin
                    eng_pop(b, f);
                    chk("R3 avail", {15'd0, f}, {15'd0, tn > 0});
                    if (tn > 0) begin
                        chk("R3 tx data", {8'd0, b}, {8'd0, tq[0]});
                        tq[0] = tq[1]; tn--;
                    end
                end
                2: begin
                    eng_push(r[7:0], f);
                    chk("R6 rx_space", {15'd0, f}, {15'd0, rn < 2});
                    if (rn < 2) begin rq[rn] = r[7:0]; rn++; end
                end
                3: begin
                    rd_reg(8'h88, d);
                    if (rn > 0) begin
                        chk("R3 rx data", d, {8'd0, rq[0]});
                        rq[0] = rq[1]; rn--;
                    end else begin
                        chk("R7 rx empty", d, 16'h0); rerr = 1;
                    end
                end
                4: begin
                    wr_reg(8'h84, r);
                    if (tn == 0) begin tq[0] = r[7:0]; tq[1] = r[15:8]; tn = 2; end
                    else werr = 1;
                end
                default: begin
                    rd_reg(8'h8C, d);
                    if (rn == 2) begin
                        chk("R4 rx pair", d, {rq[1], rq[0]}); rn = 0;
                    end else begin
                        chk("R7 rx pair short", d, 16'h0); rerr = 1;
                    end
                end
            endcase
            rd_reg(8'h2C, d); chk("R2 fill code", d, {12'd0, enc(rn), enc(tn)});
            rd_reg(8'h18, d); chk("R6 R7 error flags", d, {10'd0, werr, rerr, 4'd0});
            wr_reg(8'h18, 16'h0030);
            werr = 0; rerr = 0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule